// File: doc/BRIEF.md
# Integer ALU with Dual-Width Flags

This block is the integer execution unit of a 64-bit datapath. It takes two 64-bit operands, a carry-in bit from the condition register and a 5-bit operation code. It produces a 64-bit result and two sets of condition flags in the same cycle. One flag set describes the low 32 bits of the result and the other describes the full 64 bits, so either word size can branch on one operation. The supported operations are add and subtract (each with or without carry/borrow), six bitwise logical operations, 32x32 unsigned and signed multiplies, and left, logical-right and arithmetic-right shifts at both word sizes.

The result and the flags are combinational. The only state is a 32-bit side register. It holds the upper half of the most recent multiply product and is loaded on the rising clock edge that ends a cycle in which a multiply is selected. The shift count comes either from a 6-bit immediate field or from the low bits of the second operand, as chosen by a select input.

Each flag nibble is ordered {N, Z, V, C}: bit 3 is negative, bit 2 is zero, bit 1 is overflow and bit 0 is carry/borrow.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (add) gives a + b. Code 1 (add with carry) gives a + b + cin. The sum wraps modulo 2^64.
- R2: For codes 0 and 1, flag bit 0 of the 64-bit set is the carry out of bit 63. Flag bit 0 of the 32-bit set is the carry out of the 32-bit sum of the low words plus the carry-in.
- R3: For codes 0 and 1, flag bit 1 of each set is signed overflow at that width: a and b have the same sign, and the result sign differs from it.
- R4: Code 2 (subtract) gives a - b. Code 3 (subtract with borrow) gives a - b - cin. Flag bit 0 is set when the unsigned minuend is smaller than the subtrahend plus the borrow-in; this is evaluated on bits 63:0 for the 64-bit set and on bits 31:0 for the 32-bit set.
- R5: For codes 2 and 3, flag bit 1 of each set is signed overflow at that width: a and b differ in sign, and the result sign differs from the sign of a.
- R6: Codes 4 to 9 give a&b, a&~b, a|b, a|~b, a^b and ~(a^b) in that order. Every operation other than codes 0 to 3 clears flag bits 1 and 0 in both sets.
- R7: In both sets, flag bit 3 is the result's bit 31 (32-bit set) or bit 63 (64-bit set). Flag bit 2 is set when result bits 31:0 (32-bit set) or 63:0 (64-bit set) are all zero.
- R8: Code 10 (unsigned multiply) gives the 64-bit product of the two low words taken as unsigned. Product bits 63:32 appear on y_o after the next rising clock edge.
- R9: Code 11 (signed multiply) sign-extends both low words before multiplying. The 64-bit product is the result, and its bits 63:32 appear on y_o after the next rising clock edge.
- R10: y_o is 0 after reset. It keeps its value across every cycle whose operation code is not 10 or 11.
- R11: Codes 12, 13 and 14 are 32-bit shifts using the low 5 bits of the count. Code 12 gives the 64-bit value a shifted left. Code 13 gives the zero-extended low word shifted right. Code 14 gives the low word taken as signed, shifted right arithmetically and sign-extended to 64 bits.
- R12: Codes 15, 16 and 17 shift all 64 bits left, logical right and arithmetic right by a 6-bit count. The count is shamt_i when use_imm_i is 1 and b_i[5:0] when it is 0.
- R13: Codes 18 to 31 are unassigned. They give a zero result, which sets flag bit 2 in both sets and clears every other flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the side register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cin_i | input | 1 | Carry-in from the condition register |
| use_imm_i | input | 1 | Take the shift count from shamt_i rather than b_i |
| shamt_i | input | 6 | Immediate shift count |
| res_o | output | 64 | Result |
| flags32_o | output | 4 | {N,Z,V,C} for the low 32 bits |
| flags64_o | output | 4 | {N,Z,V,C} for the full 64 bits |
| y_o | output | 32 | Side register holding the upper product half |

## Verification
The result and both flag sets are due in the same cycle the operation and operands are applied, because no register lies on that path. The side register is due one rising edge later. The bench drives every input on the falling edge and compares the result and flags against its behavioural model 1 ns later, well before the next rising edge. At the following falling edge, before it applies new inputs, it compares y_o against the model's copy of that register. This copy is updated only when the model has just seen a multiply.

// File: rtl/int_alu.sv
module int_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  op_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic        cin_i,
  input  logic        use_imm_i,
  input  logic [5:0]  shamt_i,
  output logic [63:0] res_o,
  output logic [3:0]  flags32_o,
  output logic [3:0]  flags64_o,
  output logic [31:0] y_o
);

  localparam logic [4:0] OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3;
  localparam logic [4:0] OP_AND  = 5'd4,  OP_ANDN = 5'd5,  OP_OR   = 5'd6,  OP_ORN  = 5'd7;
  localparam logic [4:0] OP_XOR  = 5'd8,  OP_XNOR = 5'd9,  OP_UMUL = 5'd10, OP_SMUL = 5'd11;
  localparam logic [4:0] OP_SL32 = 5'd12, OP_SR32 = 5'd13, OP_SA32 = 5'd14;
  localparam logic [4:0] OP_SL64 = 5'd15, OP_SR64 = 5'd16, OP_SA64 = 5'd17;

  logic is_add, is_sub, is_mul;
  assign is_add = (op_i == OP_ADD) || (op_i == OP_ADDC);
  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC);
  assign is_mul = (op_i == OP_UMUL) || (op_i == OP_SMUL);

  logic [63:0] cin64;
  assign cin64 = {63'd0, cin_i & ((op_i == OP_ADDC) || (op_i == OP_SUBC))};

  logic [63:0] sum, diff;
  logic [32:0] sum_lo;
  assign sum    = a_i + b_i + cin64;
  assign sum_lo = {1'b0, a_i[31:0]} + {1'b0, b_i[31:0]} + {32'd0, cin64[0]};
  assign diff   = a_i + ~b_i + 64'd1 - cin64;

  logic [63:0] cvec, bvec;
  assign cvec = (a_i & b_i) | (~sum & (a_i | b_i));
  assign bvec = (~a_i & b_i) | (diff & (~a_i | b_i));

  logic [63:0] umul, smul;
  assign umul = {32'd0, a_i[31:0]} * {32'd0, b_i[31:0]};
  assign smul = $signed({{32{a_i[31]}}, a_i[31:0]}) * $signed({{32{b_i[31]}}, b_i[31:0]});

  logic [5:0] cnt;
  assign cnt = use_imm_i ? shamt_i : b_i[5:0];

  logic signed [63:0] lo_sx;
  assign lo_sx = $signed({{32{a_i[31]}}, a_i[31:0]});

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADDC: res_o = sum;
      OP_SUB, OP_SUBC: res_o = diff;
      OP_AND:  res_o = a_i & b_i;
      OP_ANDN: res_o = a_i & ~b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_ORN:  res_o = a_i | ~b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_XNOR: res_o = ~(a_i ^ b_i);
      OP_UMUL: res_o = umul;
      OP_SMUL: res_o = smul;
      OP_SL32: res_o = a_i << cnt[4:0];
      OP_SR32: res_o = {32'd0, a_i[31:0]} >> cnt[4:0];
      OP_SA32: res_o = lo_sx >>> cnt[4:0];
      OP_SL64: res_o = a_i << cnt;
      OP_SR64: res_o = a_i >> cnt;
      OP_SA64: res_o = $signed(a_i) >>> cnt;
      default: res_o = 64'd0;
    endcase
  end

  logic c32, c64, v32, v64;
  always_comb begin
    c32 = 1'b0; c64 = 1'b0; v32 = 1'b0; v64 = 1'b0;
    if (is_add) begin
      c32 = sum_lo[32];
      c64 = cvec[63];
      v32 = (a_i[31] == b_i[31]) && (b_i[31] != sum[31]);
      v64 = (a_i[63] == b_i[63]) && (b_i[63] != sum[63]);
    end else if (is_sub) begin
      c32 = bvec[31];
      c64 = bvec[63];
      v32 = (a_i[31] != b_i[31]) && (a_i[31] != diff[31]);
      v64 = (a_i[63] != b_i[63]) && (a_i[63] != diff[63]);
    end
  end

  assign flags32_o = {res_o[31], res_o[31:0] == 32'd0, v32, c32};
  assign flags64_o = {res_o[63], res_o == 64'd0, v64, c64};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y_o <= 32'd0;
    else if (is_mul) y_o <= res_o[63:32];
  end

  a_r10_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mul |=> $stable(y_o));
  a_r8_y_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_UMUL) |=> y_o == $past(res_o[63:32]));
  a_r9_y_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SMUL) |=> y_o == $past(res_o[63:32]));
  a_r7_zero_nest: assert property (@(posedge clk) disable iff (!rst_n)
    flags64_o[2] |-> flags32_o[2]);
  a_r6_logic_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_AND && op_i <= OP_XNOR) |-> (flags32_o[1:0] == 2'b00 && flags64_o[1:0] == 2'b00));
  a_r12_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SA64) |-> res_o[63] == a_i[63]);
  a_r1_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD && b_i == 64'd0) |-> (res_o == a_i && !flags64_o[0]));
  a_r13_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > OP_SA64) |-> (res_o == 64'd0 && flags64_o == 4'b0100));

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = 5'd31;
  logic [63:0] a = '0, b = '0;
  logic        cin = 1'b0, use_imm = 1'b0;
  logic [5:0]  shamt = '0;
  logic [63:0] res;
  logic [3:0]  f32, f64;
  logic [31:0] y;

  int_alu u_int_alu (.clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .cin_i(cin),
    .use_imm_i(use_imm), .shamt_i(shamt), .res_o(res), .flags32_o(f32), .flags64_o(f64), .y_o(y));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] exp_y = '0;
  string y_tag = "R10";

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] o);
    if (o <= 5'd1) return "R1";
    if (o <= 5'd3) return "R4";
    if (o <= 5'd9) return "R6";
    if (o == 5'd10) return "R8";
    if (o == 5'd11) return "R9";
    if (o <= 5'd14) return "R11";
    if (o <= 5'd17) return "R12";
    return "R13";
  endfunction

  task automatic run(input logic [4:0] o, input logic [63:0] av, input logic [63:0] bv,
                     input logic ci, input logic ui, input logic [5:0] sh);
    logic [63:0] er;
    logic c32, c64, v32, v64;
    logic [5:0] n;
    logic [64:0] t65;
    logic [32:0] t33;
    logic ce;
    @(negedge clk);
    chk(y_tag, "y_o", {32'd0, y}, {32'd0, exp_y});
    op = o; a = av; b = bv; cin = ci; use_imm = ui; shamt = sh;
    n = ui ? sh : bv[5:0];
    ce = ci && (o == 5'd1 || o == 5'd3);
    c32 = 0; c64 = 0; v32 = 0; v64 = 0;
    case (o)
      5'd0, 5'd1: begin
        t65 = {1'b0, av} + {1'b0, bv} + 65'(ce); er = t65[63:0]; c64 = t65[64];
        t33 = {1'b0, av[31:0]} + {1'b0, bv[31:0]} + 33'(ce); c32 = t33[32];
        t65 = {av[63], av} + {bv[63], bv} + 65'(ce); v64 = t65[64] ^ t65[63];
        t33 = {av[31], av[31:0]} + {bv[31], bv[31:0]} + 33'(ce); v32 = t33[32] ^ t33[31];
      end
      5'd2, 5'd3: begin
        er = av - bv - 64'(ce);
        c64 = {1'b0, av} < ({1'b0, bv} + 65'(ce));
        c32 = {1'b0, av[31:0]} < ({1'b0, bv[31:0]} + 33'(ce));
        t65 = {av[63], av} - {bv[63], bv} - 65'(ce); v64 = t65[64] ^ t65[63];
        t33 = {av[31], av[31:0]} - {bv[31], bv[31:0]} - 33'(ce); v32 = t33[32] ^ t33[31];
      end
      5'd4: er = av & ~(~bv);
      5'd5: er = av & ~bv;
      5'd6: er = av | bv;
      5'd7: er = av | ~bv;
      5'd8: er = av ^ bv;
      5'd9: er = ~av ^ bv;
      5'd10: er = 64'(av[31:0]) * 64'(bv[31:0]);
      5'd11: er = 64'($signed(av[31:0]) * $signed(bv[31:0]));
      5'd12: er = av << n[4:0];
      5'd13: er = 64'(av[31:0]) >> n[4:0];
      5'd14: er = 64'($signed(av[31:0]) >>> n[4:0]);
      5'd15: er = av << n;
      5'd16: er = av >> n;
      5'd17: er = $signed(av) >>> n;
      default: er = 64'd0;
    endcase
    #1;
    chk(tag_of(o), "res_o", res, er);
    chk((o <= 5'd1) ? "R2" : (o <= 5'd3) ? "R4" : tag_of(o), "carry", {62'd0, f32[0], f64[0]}, {62'd0, c32, c64});
    chk((o <= 5'd1) ? "R3" : (o <= 5'd3) ? "R5" : tag_of(o), "overflow", {62'd0, f32[1], f64[1]}, {62'd0, v32, v64});
    chk("R7", "nz", {60'd0, f32[3:2], f64[3:2]},
        {60'd0, er[31], er[31:0] == 32'd0, er[63], er == 64'd0});
    if (o == 5'd10 || o == 5'd11) begin exp_y = er[63:32]; y_tag = tag_of(o); end
    else y_tag = "R10";
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R10", "y_o after reset", {32'd0, y}, 64'd0);
    rst_n = 1'b1;
    run(5'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b1, 0, 0);
    run(5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 0, 0);
    run(5'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 0);
    run(5'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);
    run(5'd1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0, 0);
    run(5'd2, 64'd0, 64'd1, 1'b1, 0, 0);
    run(5'd3, 64'd5, 64'd5, 1'b1, 0, 0);
    run(5'd3, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 0, 0);
    run(5'd2, 64'h0000_0000_8000_0000, 64'd1, 0, 0, 0);
    run(5'd10, 64'hDEAD_0000_FFFF_FFFF, 64'h1234_0000_FFFF_FFFF, 0, 0, 0);
    run(5'd6, 64'h1, 64'h2, 0, 0, 0);
    run(5'd11, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_0000_0003, 0, 0, 0);
    run(5'd11, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, 0, 0);
    run(5'd14, 64'h0000_0000_8000_0000, 64'd0, 0, 1'b1, 6'd31);
    run(5'd14, 64'h0000_0000_8000_0000, 64'h3F, 0, 1'b0, 6'd0);
    run(5'd13, 64'hFFFF_FFFF_8000_0000, 64'd0, 0, 1'b1, 6'd33);
    run(5'd12, 64'h0000_0000_8000_0001, 64'd0, 0, 1'b1, 6'd1);
    run(5'd17, 64'h8000_0000_0000_0000, 64'd0, 0, 1'b1, 6'd63);
    run(5'd16, 64'h8000_0000_0000_0000, 64'h3F, 0, 1'b0, 6'd1);
    run(5'd15, 64'h1, 64'd0, 0, 1'b1, 6'd63);
    run(5'd9, 64'hF0F0, 64'hF0F0, 0, 0, 0);
    run(5'd31, rnd64(), rnd64(), 1'b1, 0, 0);
    run(5'd18, rnd64(), rnd64(), 0, 0, 0);
    for (int i = 0; i < 600; i++)
      run(5'($urandom_range(0, 19)), rnd64(), rnd64(), 1'($urandom), 1'($urandom), 6'($urandom));
    run(5'd0, 64'd0, 64'd0, 0, 0, 0);
    @(negedge clk);
    chk(y_tag, "y_o final", {32'd0, y}, {32'd0, exp_y});
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule